// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is the byte-wide register file of a hardware monitoring and fan-drive controller. A host reaches it over a plain synchronous port: one address, a write strobe and write data. Read data follows the address combinationally. It holds configuration, limit, offset, fan-parameter and drive registers, and each one has its own reset value. A separate internal update port loads the measurement and status registers. These registers are read-only to the host.

The control register at address 0x00 has a write-once lock bit. Once set, it freezes every register marked lockable until the next reset. Limits, pulse counts and the drive bytes stay writable. A shutdown bit forces both drive outputs to zero and masks the drive registers' readback. A full-speed bit forces both drive outputs to all ones. The host port has no back-pressure: the block accepts a write in the cycle its strobe is high. It applies the write at that clock edge, so there is no ready signal to wait on.

Top module: `cfg_regbank`

## Requirements
- R1: After reset, registers hold their defaults. Examples: 0x00=0x01, 0x02=0xC0, 0x05=0x0C, 0x15/0x17/0x19=0xFF, 0x1B/0x1D=0x7F, 0x1F..0x22=0x64, 0x28..0x2B=0x5A, 0x2C/0x2D=0xCC, 0x2E/0x2F=0x44, 0x30=0x80, 0x39=0x05, 0x3D=0x66, tach readings 0x48..0x4B=0xFF, tach minimums 0x4C..0x4F=0xFF. The readings 0x08..0x11 reset to 0x00.
- R2: A host write to a writable, unlocked register reads back on the next cycle.
- R3: Writing 1 to bit 1 of 0x00 sets the lock. No write can clear it; only reset releases it. `lock_active` mirrors the lock.
- R4: While locked, host writes are dropped to 0x01..0x07, 0x1E..0x38, 0x3A, 0x42, 0x43 and 0x50..0x53. They are also dropped to bits 7:4 and bit 0 of 0x00. `monitor_en` follows bit 0 of 0x00.
- R5: These stay writable while locked: 0x12..0x1D, 0x39, 0x3D, 0x40, 0x41, 0x44, 0x45 and 0x4C..0x4F. Bit 3 of 0x00 (full speed) is also always writable.
- R6: Bit 2 of 0x00 (ready) reads 0 right after reset and becomes 1 after READY_CYCLES cycles. Host writes never change it.
- R7: Bit 3 of 0x01 ignores writes and always reads 0.
- R8: Host writes to 0x08..0x11 and 0x48..0x4B have no effect. The update port loads these addresses, and update-port writes to any other address are ignored.
- R9: When a host write and an update hit the same read-only address in one cycle, the update value is stored.
- R10: 0x3E reads 0x41 and 0x3F reads 0x02; writes do not change them.
- R11: Addresses 0x3B, 0x3C, 0x46, 0x47 and all addresses at or above 0x54 read 0x00. Writes to them are discarded.
- R12: While bit 6 of 0x01 (shutdown) is 1, `drive_a`/`drive_b` are 0x00 and 0x40/0x41 read 0x00. The stored drive values return when shutdown clears.
- R13: With shutdown clear, full speed (bit 3 of 0x00) forces both drive outputs to 0xFF. Otherwise `drive_a` and `drive_b` equal registers 0x40 and 0x41.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Register address for read and write |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for host_addr |
| upd_we | input | 1 | Measurement update strobe |
| upd_addr | input | ADDR_W | Measurement update address |
| upd_data | input | DATA_W | Measurement update data |
| drive_a | output | DATA_W | First fan drive level |
| drive_b | output | DATA_W | Second fan drive level |
| lock_active | output | 1 | Lock is set |
| monitor_en | output | 1 | Start-monitoring control |

## Verification
Two things can collide in one cycle. The host can write a read-only measurement address in the same cycle the update port loads it. The bench drives both strobes at the same negative edge and expects the update value on readback. The shutdown mask and the full-speed override can also be active together. The bench enables both and expects zero drive. It then clears shutdown and expects all ones, and finally clears full speed and expects the stored drive bytes back.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {K_RW, K_MEAS, K_CONST, K_NONE} reg_kind_e;

  localparam int A_CTRL  = 'h00;
  localparam int A_MODE  = 'h01;
  localparam int A_DRV_A = 'h40;
  localparam int A_DRV_B = 'h41;
  localparam int SHDN_BIT = 6;

  function automatic reg_kind_e reg_kind(input int a);
    if ((a >= 'h08 && a <= 'h11) || (a >= 'h48 && a <= 'h4B)) return K_MEAS;
    if (a == 'h3E || a == 'h3F) return K_CONST;
    if (a == 'h3B || a == 'h3C || a == 'h46 || a == 'h47 || a >= 'h54) return K_NONE;
    return K_RW;
  endfunction

  function automatic bit reg_lockable(input int a);
    return (a <= 'h07) || (a >= 'h1E && a <= 'h3A && a != 'h39) ||
           (a == 'h42) || (a == 'h43) || (a >= 'h50 && a <= 'h53);
  endfunction

  function automatic logic [7:0] reg_default(input int a);
    if (a == 'h00) return 8'h01;
    if (a == 'h02) return 8'hC0;
    if (a == 'h05 || a == 'h06) return 8'h0C;
    if (a == 'h15 || a == 'h17 || a == 'h19) return 8'hFF;
    if (a == 'h1B || a == 'h1D) return 8'h7F;
    if (a >= 'h1F && a <= 'h22) return 8'h64;
    if (a >= 'h28 && a <= 'h2B) return 8'h5A;
    if (a == 'h2C || a == 'h2D) return 8'hCC;
    if (a == 'h2E || a == 'h2F) return 8'h44;
    if (a == 'h30 || a == 'h31) return 8'h80;
    if (a == 'h32 || a == 'h33) return 8'h60;
    if (a == 'h34 || a == 'h35) return 8'h20;
    if (a == 'h36 || a == 'h37) return 8'h3F;
    if (a == 'h39) return 8'h05;
    if (a == 'h3D) return 8'h66;
    if (a == 'h3E) return 8'h41;
    if (a == 'h3F) return 8'h02;
    if (a >= 'h48 && a <= 'h4F) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] reg_zero_mask(input int a);
    return (a == A_MODE) ? 8'h08 : 8'h00;
  endfunction
endpackage

// File: rtl/regbank_cell.sv
module regbank_cell #(
  parameter int DATA_W = 8,
  parameter regbank_pkg::reg_kind_e KIND = regbank_pkg::K_RW,
  parameter bit LOCKABLE = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter logic [DATA_W-1:0] ZERO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              locked,
  input  logic [DATA_W-1:0] wdata,
  input  logic              upd_we,
  input  logic [DATA_W-1:0] upd_data,
  output logic [DATA_W-1:0] q
);
  if (KIND == regbank_pkg::K_RW) begin : g_rw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else if (host_we && !(LOCKABLE && locked)) q <= wdata & ~ZERO_MASK;
    end
    wire unused_rw = ^{upd_we, upd_data};
  end else if (KIND == regbank_pkg::K_MEAS) begin : g_meas
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else if (upd_we) q <= upd_data;
    end
    wire unused_meas = ^{host_we, locked, wdata};
  end else begin : g_fixed
    assign q = RST_VAL;
    wire unused_fixed = ^{clk, rst_n, host_we, locked, wdata, upd_we, upd_data};
  end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 84
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] regs [NUM_REGS],
  input  logic              shdn,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] DRV_A = ADDR_W'(regbank_pkg::A_DRV_A);
  localparam logic [ADDR_W-1:0] DRV_B = ADDR_W'(regbank_pkg::A_DRV_B);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rdata = regs[i];
    if (shdn && (addr == DRV_A || addr == DRV_B)) rdata = '0;
  end
endmodule

// File: rtl/regbank_drive.sv
module regbank_drive #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lvl_a,
  input  logic [DATA_W-1:0] lvl_b,
  input  logic              shdn,
  input  logic              fspd,
  output logic [DATA_W-1:0] drive_a,
  output logic [DATA_W-1:0] drive_b
);
  always_comb begin
    if (shdn) begin
      drive_a = '0;
      drive_b = '0;
    end else if (fspd) begin
      drive_a = '1;
      drive_b = '1;
    end else begin
      drive_a = lvl_a;
      drive_b = lvl_b;
    end
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 84,
  parameter int READY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              upd_we,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [DATA_W-1:0] upd_data,
  output logic [DATA_W-1:0] drive_a,
  output logic [DATA_W-1:0] drive_b,
  output logic              lock_active,
  output logic              monitor_en
);
  import regbank_pkg::*;

  localparam int CNT_W = $clog2(READY_CYCLES + 1);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              locked, ready_q, start_q, fspd;
  logic [DATA_W-1:4] ctrl_hi_q;
  logic [CNT_W-1:0]  rdy_cnt;
  logic              shdn;
  logic              ctrl_we;

  assign ctrl_we = host_we && (host_addr == ADDR_W'(A_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_cnt <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      rdy_cnt <= rdy_cnt + 1'b1;
      if (rdy_cnt == CNT_W'(READY_CYCLES - 1)) ready_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b1;
      locked    <= 1'b0;
      fspd      <= 1'b0;
      ctrl_hi_q <= '0;
    end else if (ctrl_we) begin
      fspd <= host_wdata[3];
      if (!locked) begin
        start_q   <= host_wdata[0];
        locked    <= host_wdata[1];
        ctrl_hi_q <= host_wdata[DATA_W-1:4];
      end
    end
  end

  for (genvar a = 0; a < NUM_REGS; a++) begin : g_reg
    if (a == A_CTRL) begin : g_ctrl
      assign regs[a] = {ctrl_hi_q, fspd, ready_q, locked, start_q};
    end else begin : g_cell
      regbank_cell #(
        .DATA_W   (DATA_W),
        .KIND     (reg_kind(a)),
        .LOCKABLE (reg_lockable(a)),
        .RST_VAL  (DATA_W'(reg_default(a))),
        .ZERO_MASK(DATA_W'(reg_zero_mask(a)))
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_we (host_we && (host_addr == ADDR_W'(a))),
        .locked  (locked),
        .wdata   (host_wdata),
        .upd_we  (upd_we && (upd_addr == ADDR_W'(a))),
        .upd_data(upd_data),
        .q       (regs[a])
      );
    end
  end

  assign shdn = regs[A_MODE][SHDN_BIT];

  regbank_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rdmux (
    .addr (host_addr),
    .regs (regs),
    .shdn (shdn),
    .rdata(host_rdata)
  );

  regbank_drive #(.DATA_W(DATA_W)) u_drive (
    .lvl_a  (regs[A_DRV_A]),
    .lvl_b  (regs[A_DRV_B]),
    .shdn   (shdn),
    .fspd   (fspd),
    .drive_a(drive_a),
    .drive_b(drive_b)
  );

  assign lock_active = locked;
  assign monitor_en  = start_q;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic [DATA_W-1:0] drive_a,
  input logic [DATA_W-1:0] drive_b,
  input logic              lock_active,
  input logic              monitor_en,
  input logic              ready_flag,
  input logic              shdn,
  input logic              fspd
);
  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> lock_active);

  // R4
  monitor_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> $stable(monitor_en));

  // R6
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_flag |=> ready_flag);

  // R7
  mode_bit3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == ADDR_W'('h01)) |-> (host_rdata[3] == 1'b0));

  // R10
  const_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == ADDR_W'('h3E)) |-> (host_rdata == DATA_W'('h41)));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == ADDR_W'('h3B)) |-> (host_rdata == '0));

  // R12
  shdn_drive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |-> (drive_a == '0 && drive_b == '0));

  // R12
  shdn_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn && (host_addr == ADDR_W'('h40) || shdn && host_addr == ADDR_W'('h41)))
      |-> (host_rdata == '0));

  // R13
  fspd_drive_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fspd && !shdn) |-> (drive_a == '1 && drive_b == '1));
endmodule

bind cfg_regbank regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .drive_a    (drive_a),
  .drive_b    (drive_b),
  .lock_active(lock_active),
  .monitor_en (monitor_en),
  .ready_flag (ready_q),
  .shdn       (shdn),
  .fspd       (fspd)
);

// File: tb/tb_cfg_regbank.sv
`timescale 1ns/1ps
module tb_cfg_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] host_addr = '0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       upd_we = 1'b0;
  logic [6:0] upd_addr = '0;
  logic [7:0] upd_data = '0;
  logic [7:0] drive_a, drive_b;
  logic       lock_active, monitor_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cfg_regbank dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .upd_we(upd_we),
    .upd_addr(upd_addr), .upd_data(upd_data), .drive_a(drive_a),
    .drive_b(drive_b), .lock_active(lock_active), .monitor_en(monitor_en)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    host_we = 1'b0;
    upd_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [7:0] exp);
    host_addr = a;
    #1;
    chk(req, host_rdata, exp);
  endtask

  task automatic upd(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    upd_addr = a; upd_data = d; upd_we = 1'b1;
    @(negedge clk);
    upd_we = 1'b0;
  endtask

  task automatic t_defaults();
    rd_chk("R6 ready low after reset", 7'h00, 8'h01);
    chk("R3 lock clear after reset", {7'b0, lock_active}, 8'h00);
    chk("R13 monitor_en default", {7'b0, monitor_en}, 8'h01);
    rd_chk("R1 0x02", 7'h02, 8'hC0);
    rd_chk("R1 0x05", 7'h05, 8'h0C);
    rd_chk("R1 0x15", 7'h15, 8'hFF);
    rd_chk("R1 0x1B", 7'h1B, 8'h7F);
    rd_chk("R1 0x20", 7'h20, 8'h64);
    rd_chk("R1 0x2B", 7'h2B, 8'h5A);
    rd_chk("R1 0x2C", 7'h2C, 8'hCC);
    rd_chk("R1 0x2F", 7'h2F, 8'h44);
    rd_chk("R1 0x30", 7'h30, 8'h80);
    rd_chk("R1 0x39", 7'h39, 8'h05);
    rd_chk("R1 0x3D", 7'h3D, 8'h66);
    rd_chk("R1 0x49", 7'h49, 8'hFF);
    rd_chk("R1 0x4E", 7'h4E, 8'hFF);
    rd_chk("R1 0x0C", 7'h0C, 8'h00);
    chk("R13 drive_a default", drive_a, 8'h00);
  endtask

  task automatic t_ready();
    repeat (20) @(negedge clk);
    rd_chk("R6 ready set", 7'h00, 8'h05);
    wr(7'h00, 8'h00);
    rd_chk("R6 ready ignores write", 7'h00, 8'h04);
    chk("R13 monitor_en follows bit0", {7'b0, monitor_en}, 8'h00);
    wr(7'h00, 8'h01);
  endtask

  task automatic t_rw();
    wr(7'h1F, 8'h50);
    rd_chk("R2 therm write", 7'h1F, 8'h50);
    wr(7'h52, 8'hA3);
    rd_chk("R2 test write", 7'h52, 8'hA3);
    wr(7'h01, 8'h08);
    rd_chk("R7 bit3 only", 7'h01, 8'h00);
    wr(7'h01, 8'hFF);
    rd_chk("R7 all ones", 7'h01, 8'hF7);
    wr(7'h01, 8'h00);
  endtask

  task automatic t_readonly();
    wr(7'h0A, 8'h77);
    rd_chk("R8 host write to reading", 7'h0A, 8'h00);
    upd(7'h0A, 8'h9C);
    rd_chk("R8 update loads reading", 7'h0A, 8'h9C);
    upd(7'h49, 8'h12);
    rd_chk("R8 update loads tach", 7'h49, 8'h12);
    upd(7'h14, 8'h11);
    rd_chk("R8 update ignored on limit", 7'h14, 8'h00);
    // R9: host write and update on the same read-only address in one cycle
    @(negedge clk);
    host_addr = 7'h0D; host_wdata = 8'h11; host_we = 1'b1;
    upd_addr = 7'h0D; upd_data = 8'h22; upd_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0; upd_we = 1'b0;
    rd_chk("R9 update wins", 7'h0D, 8'h22);
    wr(7'h3E, 8'h00);
    rd_chk("R10 id fixed", 7'h3E, 8'h41);
    wr(7'h3F, 8'hFF);
    rd_chk("R10 revision fixed", 7'h3F, 8'h02);
    wr(7'h3B, 8'h5A);
    rd_chk("R11 not-used reads zero", 7'h3B, 8'h00);
    wr(7'h60, 8'h5A);
    rd_chk("R11 above map reads zero", 7'h60, 8'h00);
  endtask

  task automatic t_drive();
    wr(7'h40, 8'h3C);
    wr(7'h41, 8'hA5);
    #1;
    chk("R13 drive_a follows reg", drive_a, 8'h3C);
    chk("R13 drive_b follows reg", drive_b, 8'hA5);
    wr(7'h01, 8'h40);
    #1;
    chk("R12 shutdown drive_a", drive_a, 8'h00);
    chk("R12 shutdown drive_b", drive_b, 8'h00);
    rd_chk("R12 shutdown reads 0x40", 7'h40, 8'h00);
    wr(7'h00, 8'h09);
    #1;
    chk("R12 shutdown beats full speed", drive_a, 8'h00);
    wr(7'h01, 8'h00);
    #1;
    chk("R13 full speed drive_a", drive_a, 8'hFF);
    chk("R13 full speed drive_b", drive_b, 8'hFF);
    wr(7'h00, 8'h01);
    #1;
    chk("R12 stored drive returns", drive_a, 8'h3C);
    rd_chk("R12 stored 0x41 returns", 7'h41, 8'hA5);
  endtask

  task automatic t_lock();
    wr(7'h00, 8'h03);
    rd_chk("R3 lock set", 7'h00, 8'h07);
    chk("R3 lock_active", {7'b0, lock_active}, 8'h01);
    wr(7'h00, 8'hF8);
    rd_chk("R4 only full speed writable", 7'h00, 8'h0F);
    chk("R3 lock not cleared", {7'b0, lock_active}, 8'h01);
    chk("R4 monitor_en frozen", {7'b0, monitor_en}, 8'h01);
    chk("R5 full speed while locked", drive_a, 8'hFF);
    wr(7'h00, 8'h00);
    rd_chk("R5 full speed cleared", 7'h00, 8'h07);
    wr(7'h1F, 8'h33);
    rd_chk("R4 therm frozen", 7'h1F, 8'h50);
    wr(7'h01, 8'h40);
    rd_chk("R4 mode frozen", 7'h01, 8'h00);
    wr(7'h52, 8'h00);
    rd_chk("R4 test frozen", 7'h52, 8'hA3);
    wr(7'h15, 8'h12);
    rd_chk("R5 limit writable", 7'h15, 8'h12);
    wr(7'h39, 8'h07);
    rd_chk("R5 pulses writable", 7'h39, 8'h07);
    wr(7'h40, 8'h55);
    rd_chk("R5 drive writable", 7'h40, 8'h55);
    chk("R13 drive_a after locked write", drive_a, 8'h55);
    wr(7'h4D, 8'h21);
    rd_chk("R5 tach min writable", 7'h4D, 8'h21);
    do_reset();
    #1;
    chk("R3 reset releases lock", {7'b0, lock_active}, 8'h00);
    rd_chk("R1 therm default after reset", 7'h1F, 8'h64);
    wr(7'h1F, 8'h44);
    rd_chk("R3 writable after reset", 7'h1F, 8'h44);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_defaults();
    t_ready();
    t_rw();
    t_readonly();
    t_drive();
    t_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule